// File: doc/BRIEF.md
# Programmable Burst Column Generator

This block turns a single read or write command into the sequence of column addresses that a synchronous memory page sees during a burst. A command carries a start column, a burst-length code, an ordering choice (sequential or interleaved), a read/write flag and an auto-precharge flag. The block then presents one column per clock. It flags the final beat of a counted burst and pulses a precharge request one clock after that beat when the command asked for auto-precharge.

A full-page burst walks all columns of the page and wraps around without end. Only a stop input or a new command ends it. Any new command may interrupt a burst in progress, because the column may change on every clock. Read beats are also sent down a short delay line, so that a read-data-valid strobe appears 1, 2 or 3 clocks after each read column, as a live latency input selects. The mode settings are plain inputs sampled with each command. No data is stored.

Top module: `burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it, col_valid_o, last_o, precharge_o and rd_valid_o are all low.
- R2: A command sampled on a clock edge (cmd_i high) presents its start column on col_o with col_valid_o high in the following cycle. The length code, order, read flag and auto-precharge flag are captured with it.
- R3: With order_i = 0 (sequential), beat i of a burst of length N is (start with its low log2(N) bits cleared) OR ((start + i) mod N). The count wraps inside the aligned block.
- R4: With order_i = 1 (interleaved), beat i is (start with its low log2(N) bits cleared) OR ((start XOR i) mod N).
- R5: len_code_i values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. col_valid_o stays high for exactly that many cycles, and last_o is high only on the final beat; a length of 1 makes the first beat the last.
- R6: len_code_i values 4 to 7 select a full-page burst over 256 columns that wraps from column 255 to 0. last_o never rises during it, and it runs until stop or a new command.
- R7: stop_i sampled high during a burst with no command in the same cycle makes col_valid_o low in the next cycle. When cmd_i and stop_i are both high, the new command wins.
- R8: A command sampled during a burst abandons the old burst and presents the new start column in the next cycle.
- R9: precharge_o pulses for one cycle in the cycle after a last beat whose command had auto-precharge set. It stays low if a new command is sampled on that last beat, and after a stopped or interrupted burst.
- R10: rd_valid_o rises L cycles after each cycle that shows a read beat, where L is lat_i with 0 treated as 1. Write beats never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | Start a burst this cycle |
| cmd_col_i | input | 8 | Start column of the command |
| len_code_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 4-7: full page) |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| cmd_rd_i | input | 1 | 1 read, 0 write |
| cmd_ap_i | input | 1 | Auto-precharge requested at burst end |
| stop_i | input | 1 | Terminate the running burst |
| lat_i | input | 2 | Read latency in clocks (0 and 1 mean 1) |
| col_o | output | 8 | Current column address |
| col_valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Current beat is the final beat of a counted burst |
| precharge_o | output | 1 | Auto-precharge request, one cycle |
| rd_valid_o | output | 1 | Delayed read-beat strobe |

## Verification
Two pairs of events can land in the same cycle. The first is a new command on the final beat of an auto-precharge burst. The bench raises cmd_i, together with stop_i, in exactly the cycle where last_o is high. It then judges that the new burst starts at once and that no precharge pulse follows. The second is a command issued mid-burst, which must replace the old sequence on the next beat and leave the old one's precharge unissued. Full-page runs pass column 255 to confirm the wrap, and latency runs sweep every code.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd4
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;

  always_comb begin
    low_seq = (base_i + beat_i) & mask_i;
    low_ilv = (base_i ^ beat_i) & mask_i;
    col_o   = (base_i & ~mask_i) | (ilv_i ? low_ilv : low_seq);
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] cmd_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             order_i,
  input  logic             cmd_rd_i,
  input  logic             cmd_ap_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             rd_o,
  output logic             ap_o,
  output logic             last_o
);
  localparam int MAX_CODE = 3;

  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q, mask_q, mask_new;
  logic             full_q, full_new;
  logic             ilv_q, rd_q, ap_q;
  logic             cfg_en, beat_en;

  // decode the length code into a mask over the low column bits
  always_comb begin
    full_new = (int'(len_code_i) > MAX_CODE);
    mask_new = '1;
    if (!full_new) mask_new = COL_W'((1 << len_code_i) - 1);
  end

  assign last_o = active_q & ~full_q & (beat_q == mask_q);

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (cmd_i) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (active_q) begin
      if (stop_i || last_o) active_d = 1'b0;
      else                  beat_d   = beat_q + 1'b1;
    end
  end

  assign cfg_en  = cmd_i;
  assign beat_en = cmd_i | active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      if (beat_en) beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      rd_q   <= 1'b0;
      ap_q   <= 1'b0;
    end else if (cfg_en) begin
      base_q <= cmd_col_i;
      mask_q <= mask_new;
      full_q <= full_new;
      ilv_q  <= (order_i == ORD_ILV);
      rd_q   <= cmd_rd_i;
      ap_q   <= cmd_ap_i;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
  assign rd_o     = rd_q;
  assign ap_o     = ap_q;
endmodule

// File: rtl/read_lat_pipe.sv
module read_lat_pipe #(
  parameter int MAX_LAT = 3,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_i,
  input  logic [SEL_W-1:0] lat_i,
  output logic             out_o
);
  logic [MAX_LAT-1:0] pipe_q, pipe_d;
  int                 tap;

  for (genvar g = 0; g < MAX_LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign pipe_d[g] = in_i;
    end else begin : g_body
      assign pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  always_comb begin
    tap = int'(lat_i);
    if (tap < 1)       tap = 1;
    if (tap > MAX_LAT) tap = MAX_LAT;
    out_o = pipe_q[tap-1];
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W   = 8,
  parameter int LEN_W   = 3,
  parameter int MAX_LAT = 3,
  parameter int LAT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] cmd_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             order_i,
  input  logic             cmd_rd_i,
  input  logic             cmd_ap_i,
  input  logic             stop_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_valid_o,
  output logic             last_o,
  output logic             precharge_o,
  output logic             rd_valid_o
);
  logic             active;
  logic [COL_W-1:0] beat, base, mask;
  logic             ilv, rd, ap, last;
  logic             pc_q, pc_d;

  burst_seq_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .cmd_col_i  (cmd_col_i),
    .len_code_i (len_code_i),
    .order_i    (order_i),
    .cmd_rd_i   (cmd_rd_i),
    .cmd_ap_i   (cmd_ap_i),
    .stop_i     (stop_i),
    .active_o   (active),
    .beat_o     (beat),
    .base_o     (base),
    .mask_o     (mask),
    .ilv_o      (ilv),
    .rd_o       (rd),
    .ap_o       (ap),
    .last_o     (last)
  );

  burst_addr_gen #(.COL_W(COL_W)) i_addr (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (col_o)
  );

  read_lat_pipe #(.MAX_LAT(MAX_LAT), .SEL_W(LAT_W)) i_rdlat (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  (active & rd),
    .lat_i (lat_i),
    .out_o (rd_valid_o)
  );

  assign pc_d = last & ap & ~cmd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= 1'b0;
    else        pc_q <= pc_d;
  end

  assign col_valid_o = active;
  assign last_o      = last;
  assign precharge_o = pc_q;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_i,
  input logic [COL_W-1:0] cmd_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic             last_o,
  input logic             precharge_o
);
  // R2: a command shows its start column next cycle
  assert_cmd_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i |=> (col_valid_o && col_o == $past(cmd_col_i)));

  // R5: last beat only while a beat is presented
  assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> col_valid_o);

  // R5: a counted burst ends after its last beat
  assert_end_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !cmd_i) |=> !col_valid_o);

  // R7: stop without a command ends the burst
  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && stop_i && !cmd_i) |=> !col_valid_o);

  // R9: precharge only follows a last beat that was not interrupted
  assert_pc_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_o |-> ($past(last_o) && !$past(cmd_i)));

  // R9: precharge lasts one cycle
  assert_pc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_o |=> !precharge_o);
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_i       (cmd_i),
  .cmd_col_i   (cmd_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .col_valid_o (col_valid_o),
  .last_o      (last_o),
  .precharge_o (precharge_o)
);

// File: tb/test_burst_colgen.sv
`timescale 1ns/1ps
module test_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_i, order_i, cmd_rd_i, cmd_ap_i, stop_i;
  logic [7:0] cmd_col_i;
  logic [2:0] len_code_i;
  logic [1:0] lat_i;
  logic [7:0] col_o;
  logic       col_valid_o, last_o, precharge_o, rd_valid_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  burst_colgen i_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .cmd_col_i(cmd_col_i),
    .len_code_i(len_code_i), .order_i(order_i), .cmd_rd_i(cmd_rd_i),
    .cmd_ap_i(cmd_ap_i), .stop_i(stop_i), .lat_i(lat_i), .col_o(col_o),
    .col_valid_o(col_valid_o), .last_o(last_o), .precharge_o(precharge_o),
    .rd_valid_o(rd_valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int blen(input int code);
    return (code >= 4) ? 256 : (1 << code);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] b, input int i,
                                         input int code, input bit il);
    logic [7:0] m;
    m = 8'(blen(code) - 1);
    if (il) return (b & ~m) | ((b ^ 8'(i)) & m);
    return (b & ~m) | ((b + 8'(i)) & m);
  endfunction

  // drive a command for the next rising edge (call at a falling edge)
  task automatic put_cmd(input logic [7:0] c, input int code, input bit il,
                         input bit rd, input bit ap);
    cmd_i = 1'b1; cmd_col_i = c; len_code_i = 3'(code);
    order_i = il; cmd_rd_i = rd; cmd_ap_i = ap;
  endtask

  task automatic t_reset();
    chk(!col_valid_o && !last_o && !precharge_o && !rd_valid_o, "R1",
        "outputs after reset", {col_valid_o, last_o, precharge_o, rd_valid_o}, 0);
  endtask

  task automatic t_burst(input string req, input logic [7:0] c, input int code,
                         input bit il, input bit ap);
    int n = blen(code);
    @(negedge clk); put_cmd(c, code, il, 1'b0, ap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmd_i = 1'b0;
      chk(col_valid_o, req, "valid during beat", col_valid_o, 1);
      chk(col_o == exp_col(c, i, code, il), req, "column", col_o, exp_col(c, i, code, il));
      chk(last_o == (i == n - 1), "R5", "last flag", last_o, i == n - 1);
    end
    @(negedge clk);
    chk(!col_valid_o, "R5", "valid after burst", col_valid_o, 0);
    chk(precharge_o == ap, "R9", "precharge after last", precharge_o, ap);
    @(negedge clk);
    chk(!precharge_o, "R9", "precharge width", precharge_o, 0);
  endtask

  task automatic t_full_stop(input logic [7:0] c, input bit il, input int nstop);
    @(negedge clk); put_cmd(c, 4 + (il ? 3 : 0), il, 1'b0, 1'b1);
    for (int i = 0; i <= nstop; i++) begin
      @(negedge clk); cmd_i = 1'b0;
      chk(col_valid_o && col_o == exp_col(c, i, 4, il), "R6", "full page column",
          col_o, exp_col(c, i, 4, il));
      chk(!last_o, "R6", "no last in full page", last_o, 0);
      stop_i = (i == nstop);
    end
    @(negedge clk); stop_i = 1'b0;
    chk(!col_valid_o, "R7", "valid after stop", col_valid_o, 0);
    chk(!precharge_o, "R9", "no precharge after stop", precharge_o, 0);
  endtask

  task automatic t_interrupt();
    @(negedge clk); put_cmd(8'h15, 3, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cmd_i = 1'b0;
      chk(col_o == exp_col(8'h15, i, 3, 1'b0), "R8", "old burst column",
          col_o, exp_col(8'h15, i, 3, 1'b0));
    end
    put_cmd(8'h42, 2, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cmd_i = 1'b0;
      chk(col_valid_o && col_o == exp_col(8'h42, i, 2, 1'b1), "R8", "new burst column",
          col_o, exp_col(8'h42, i, 2, 1'b1));
      chk(!precharge_o, "R9", "no precharge for abandoned burst", precharge_o, 0);
    end
    @(negedge clk);
    chk(!col_valid_o && !precharge_o, "R8", "idle after new burst",
        {col_valid_o, precharge_o}, 0);
  endtask

  task automatic t_collide();
    @(negedge clk); put_cmd(8'h07, 2, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cmd_i = 1'b0;
    end
    chk(last_o, "R5", "last before collision", last_o, 1);
    put_cmd(8'h80, 1, 1'b0, 1'b0, 1'b0);
    stop_i = 1'b1;
    @(negedge clk); cmd_i = 1'b0; stop_i = 1'b0;
    chk(col_valid_o && col_o == 8'h80, "R7", "command beats stop", col_o, 8'h80);
    chk(!precharge_o, "R9", "precharge suppressed by command", precharge_o, 1'b0);
    @(negedge clk);
    chk(col_o == 8'h81 && last_o, "R3", "second beat of new burst", col_o, 8'h81);
    @(negedge clk);
    chk(!col_valid_o && !precharge_o, "R9", "idle no precharge",
        {col_valid_o, precharge_o}, 0);
  endtask

  task automatic t_latency(input int code, input bit rd);
    int d = (code < 1) ? 1 : code;
    @(negedge clk); lat_i = 2'(code); put_cmd(8'h30, 1, 1'b0, rd, 1'b0);
    for (int k = 1; k <= 7; k++) begin
      bit e;
      @(negedge clk); cmd_i = 1'b0;
      e = rd && (k == 1 + d || k == 2 + d);
      chk(rd_valid_o == e, "R10", $sformatf("rd_valid lat=%0d rd=%0d k=%0d", code, rd, k),
          rd_valid_o, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_i = 0; cmd_col_i = 0; len_code_i = 0; order_i = 0;
    cmd_rd_i = 0; cmd_ap_i = 0; stop_i = 0; lat_i = 2'd1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst("R2", 8'h5A, 0, 1'b0, 1'b1);
    t_burst("R3", 8'h5A, 1, 1'b0, 1'b0);
    t_burst("R3", 8'h2E, 2, 1'b0, 1'b1);
    t_burst("R3", 8'hC5, 3, 1'b0, 1'b1);
    t_burst("R4", 8'hC5, 3, 1'b1, 1'b0);
    t_burst("R4", 8'h13, 2, 1'b1, 1'b1);
    t_burst("R4", 8'hFF, 1, 1'b1, 1'b0);
    t_full_stop(8'hF0, 1'b0, 300);
    t_full_stop(8'h3C, 1'b1, 260);
    t_full_stop(8'h00, 1'b0, 0);
    t_interrupt();
    t_collide();
    for (int l = 0; l < 4; l++) t_latency(l, 1'b1);
    t_latency(2, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule